// File: doc/BRIEF.md
# Four-Way Hit Merger with Event Time Averaging

This block takes time-stamped hit records from four upstream sources. Each source sits behind a first-word-fall-through FIFO whose head word is always visible. Every cycle the block pops the earliest head among the sources that hold data, so the hits come out as one stream sorted by time. It then gathers consecutive hits into events. An event begins at its first hit. A later hit joins the event while its time lies no further than a programmable window past that first hit.

An event closes in one of two ways: a hit arrives beyond the window, or the inputs stay empty for a fixed number of cycles. When it closes, a sequential restoring divider works out the mean of the accumulated hit times. The block then presents one trigger primitive for a single cycle. The primitive carries the averaged fine time, the number of hits and a flag that marks an event with more hits than the accumulator keeps. The sources are stalled while the divider runs.

Top module: `hit_event_merger`

## Requirements
- R1: In a cycle where the block is collecting hits, at most one `src_pop` bit is high, and only for a source whose `src_valid` is high. The popped source is the one with the smallest head time; among equal times the lowest source index wins.
- R2: With no event open, the selected hit is popped and opens an event. With an event open, a hit whose time is at most first-hit time plus `cfg_window` is popped and joins the event. Equality counts as inside.
- R3: With an event open, a selected hit whose time exceeds first-hit time plus `cfg_window` is not popped. It closes the event and becomes the first hit of the next event.
- R4: An open event closes in the cycle that completes TIMEOUT (default 8) consecutive cycles with an event open and no source valid. Fewer idle cycles leave it open.
- R5: Only the first MAXH (default 16) hits of an event enter the sum. `prim_count` counts every hit and saturates at 2^CNTW-1 (63). `prim_sat` is 1 exactly when `prim_count` is greater than MAXH.
- R6: `prim_time` is the sum of the accumulated hit times divided by the number of accumulated hits, min(count, MAXH), with the fraction truncated.
- R7: `prim_valid` is high for exactly one cycle, SW+2 cycles after the cycle in which the event closed, where SW = TW + log2(MAXH) = 20. No source is popped from the closing cycle through the cycle in which `prim_valid` is high.
- R8: During and right after reset, no event is open and `prim_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_window | input | TW (16) | Coincidence window added to the first hit time |
| src_valid | input | NSRC (4) | Source FIFO holds a word at its head |
| src_time | input | NSRC*TW (64) | Head hit times; source i in bits [i*TW +: TW] |
| src_pop | output | NSRC (4) | Pop strobe per source, one-hot or zero |
| prim_valid | output | 1 | Trigger primitive present (one-cycle pulse) |
| prim_time | output | TW (16) | Averaged fine time of the event |
| prim_count | output | CNTW (6) | Hits in the event, saturating |
| prim_sat | output | 1 | Event held more hits than were summed |

## Verification
The assertions assume three things about the inputs: each source delivers its times in nondecreasing order, `src_valid` stays steady except after a pop, and times plus the window never wrap past the time width. The stimulus meets all three. Every source is modelled as a queue filled with sorted times well below 2^16. Heads are driven only just after a clock edge and change only when that queue is popped. The window is held constant inside each scenario. The stimulus covers equal times across all four sources, a hit landing exactly on the window edge, idle gaps just short of and beyond the timeout, and events past the accumulator limit.

// File: rtl/hem_pkg.sv
package hem_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_DIVIDE  = 2'd1,
    ST_EMIT    = 2'd2
  } hem_state_e;
endpackage

// File: rtl/hem_merge_sel.sv
// Picks the earliest head among valid sources; strict compare keeps lowest index on ties.
module hem_merge_sel #(
  parameter int NSRC = 4,
  parameter int TW   = 16,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]    src_valid,
  input  logic [NSRC*TW-1:0] src_time,
  output logic               sel_valid,
  output logic [SELW-1:0]    sel_idx,
  output logic [TW-1:0]      sel_time
);
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    sel_time  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_valid[i] && (!sel_valid || (src_time[i*TW +: TW] < sel_time))) begin
        sel_valid = 1'b1;
        sel_idx   = SELW'(i);
        sel_time  = src_time[i*TW +: TW];
      end
    end
  end
endmodule

// File: rtl/hem_seq_div.sv
// Restoring divider, one quotient bit per cycle, NW cycles after start.
module hem_seq_div #(
  parameter int NW = 20,
  parameter int DW = 5,
  parameter int QW = 16,
  localparam int SCW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic [QW-1:0] quotient
);
  logic [NW-1:0]  dvd_q, dvd_d;
  logic [DW-1:0]  dvs_q;
  logic [DW-1:0]  rem_q, rem_d;
  logic [SCW-1:0] step_q;
  logic [DW:0]    trial, diff;

  always_comb begin
    trial = {rem_q, dvd_q[NW-1]};
    diff  = trial - {1'b0, dvs_q};
    if (trial >= {1'b0, dvs_q}) begin
      rem_d = diff[DW-1:0];
      dvd_d = {dvd_q[NW-2:0], 1'b1};
    end else begin
      rem_d = trial[DW-1:0];
      dvd_d = {dvd_q[NW-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      step_q <= '0;
    end else if (start) begin
      dvd_q  <= dividend;
      dvs_q  <= divisor;
      rem_q  <= '0;
      step_q <= SCW'(NW);
    end else if (step_q != '0) begin
      dvd_q  <= dvd_d;
      rem_q  <= rem_d;
      step_q <= step_q - SCW'(1);
    end
  end

  assign busy     = (step_q != '0);
  assign quotient = dvd_q[QW-1:0];
endmodule

// File: rtl/hit_event_merger.sv
module hit_event_merger
  import hem_pkg::*;
#(
  parameter int NSRC    = 4,
  parameter int TW      = 16,
  parameter int MAXH    = 16,
  parameter int CNTW    = 6,
  parameter int TIMEOUT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TW-1:0]      cfg_window,
  input  logic [NSRC-1:0]    src_valid,
  input  logic [NSRC*TW-1:0] src_time,
  output logic [NSRC-1:0]    src_pop,
  output logic               prim_valid,
  output logic [TW-1:0]      prim_time,
  output logic [CNTW-1:0]    prim_count,
  output logic               prim_sat
);
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int ACCW = $clog2(MAXH + 1);
  localparam int SW   = TW + $clog2(MAXH);
  localparam int IDW  = $clog2(TIMEOUT + 1);

  hem_state_e      state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [SW-1:0]   sum_q, sum_d;
  logic [TW-1:0]   first_q, first_d;
  logic [IDW-1:0]  idle_q, idle_d;

  logic            sel_valid;
  logic [SELW-1:0] sel_idx;
  logic [TW-1:0]   sel_time;
  logic            ev_open, in_win, take, close;
  logic [ACCW-1:0] acc;
  logic            div_busy;
  logic [TW-1:0]   quo;

  hem_merge_sel #(.NSRC(NSRC), .TW(TW)) u_sel (
    .src_valid (src_valid),
    .src_time  (src_time),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sel_time  (sel_time)
  );

  assign ev_open = (cnt_q != '0);
  assign in_win  = ({1'b0, sel_time} <= ({1'b0, first_q} + {1'b0, cfg_window}));
  assign take    = (state_q == ST_COLLECT) && sel_valid && (!ev_open || in_win);
  assign close   = (state_q == ST_COLLECT) && ev_open &&
                   (sel_valid ? !in_win : (idle_q == IDW'(TIMEOUT - 1)));
  assign acc     = (cnt_q > CNTW'(MAXH)) ? ACCW'(MAXH) : ACCW'(cnt_q);
  assign src_pop = take ? (NSRC'(1) << sel_idx) : '0;

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sum_d   = sum_q;
    first_d = first_q;
    idle_d  = idle_q;
    case (state_q)
      ST_COLLECT: begin
        if (take) begin
          idle_d = '0;
          if (!ev_open) begin
            first_d = sel_time;
            sum_d   = SW'(sel_time);
            cnt_d   = CNTW'(1);
          end else begin
            if (cnt_q < CNTW'(MAXH)) sum_d = sum_q + SW'(sel_time);
            if (cnt_q != {CNTW{1'b1}}) cnt_d = cnt_q + CNTW'(1);
          end
        end else if (close) begin
          state_d = ST_DIVIDE;
        end else if (ev_open && !sel_valid) begin
          idle_d = idle_q + IDW'(1);
        end
      end
      ST_DIVIDE: if (!div_busy) state_d = ST_EMIT;
      ST_EMIT: begin
        state_d = ST_COLLECT;
        cnt_d   = '0;
        idle_d  = '0;
      end
      default: state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      sum_q   <= '0;
      first_q <= '0;
      idle_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sum_q   <= sum_d;
      first_q <= first_d;
      idle_q  <= idle_d;
    end
  end

  hem_seq_div #(.NW(SW), .DW(ACCW), .QW(TW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (close),
    .dividend (sum_q),
    .divisor  (acc),
    .busy     (div_busy),
    .quotient (quo)
  );

  assign prim_valid = (state_q == ST_EMIT);
  assign prim_time  = quo;
  assign prim_count = cnt_q;
  assign prim_sat   = (cnt_q > CNTW'(MAXH));
endmodule

// File: rtl/hem_checker.sv
module hem_checker #(
  parameter int NSRC = 4,
  parameter int MAXH = 16,
  parameter int CNTW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_valid,
  input logic [NSRC-1:0] src_pop,
  input logic            prim_valid,
  input logic [CNTW-1:0] prim_count,
  input logic            prim_sat
);
  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_pop));                                          // R1
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pop & ~src_valid) == '0);                               // R1
  AST_EMIT_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> (src_pop == '0));                             // R7
  AST_EMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |=> !prim_valid);                                 // R7
  AST_SAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> (prim_sat == (prim_count > CNTW'(MAXH))));    // R5
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    prim_valid |-> (prim_count != '0));                          // R2
endmodule

bind hit_event_merger hem_checker #(.NSRC(NSRC), .MAXH(MAXH), .CNTW(CNTW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_valid  (src_valid),
  .src_pop    (src_pop),
  .prim_valid (prim_valid),
  .prim_count (prim_count),
  .prim_sat   (prim_sat)
);

// File: tb/test_hit_event_merger.sv
module test_hit_event_merger;
  localparam int NSRC = 4, TW = 16, MAXH = 16, CNTW = 6, TIMEOUT = 8;
  localparam int SW = TW + $clog2(MAXH);
  localparam int CMAX = (1 << CNTW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic [TW-1:0]      cfg_window;
  logic [NSRC-1:0]    src_valid;
  logic [NSRC*TW-1:0] src_time;
  logic [NSRC-1:0]    src_pop;
  logic               prim_valid;
  logic [TW-1:0]      prim_time;
  logic [CNTW-1:0]    prim_count;
  logic               prim_sat;

  hit_event_merger #(.NSRC(NSRC), .TW(TW), .MAXH(MAXH), .CNTW(CNTW), .TIMEOUT(TIMEOUT))
  i_hit_event_merger (
    .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window), .src_valid(src_valid),
    .src_time(src_time), .src_pop(src_pop), .prim_valid(prim_valid),
    .prim_time(prim_time), .prim_count(prim_count), .prim_sat(prim_sat)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int q [NSRC][$];
  int got_time[$], got_cnt[$], got_sat[$];
  // reference model state: 0 collect, 1 divide, 2 emit
  int m_mode, m_cnt, m_acc, m_sum, m_first, m_idle, m_t, e_time, e_cnt, e_sat;
  logic [31:0] seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_inputs();
    for (int i = 0; i < NSRC; i++) begin
      src_valid[i] = (q[i].size() > 0);
      src_time[i*TW +: TW] = (q[i].size() > 0) ? TW'(q[i][0]) : '0;
    end
  endtask

  task automatic step();
    int pop_idx, sel, t, win;
    bit do_close;
    logic [NSRC-1:0] exp_pop;
    @(negedge clk);
    pop_idx = -1; sel = -1; t = 0; do_close = 0; exp_pop = '0;
    win = int'(cfg_window);
    if (m_mode == 0) begin
      for (int i = 0; i < NSRC; i++)
        if (q[i].size() > 0 && (sel < 0 || q[i][0] < t)) begin sel = i; t = q[i][0]; end
      if (sel >= 0) begin
        if (m_cnt == 0 || t <= m_first + win) begin
          pop_idx = sel; exp_pop[sel] = 1'b1; m_idle = 0;
          if (m_cnt == 0) begin m_first = t; m_sum = t; m_acc = 1; m_cnt = 1; end
          else begin
            if (m_acc < MAXH) begin m_sum += t; m_acc++; end
            if (m_cnt < CMAX) m_cnt++;
          end
        end else do_close = 1;
      end else if (m_cnt != 0) begin
        if (m_idle == TIMEOUT - 1) do_close = 1; else m_idle++;
      end
    end
    // R1 R2 R3 R4: pop choice every cycle
    check(src_pop == exp_pop, "R1 R2 R3 R4 pop", int'(src_pop), int'(exp_pop));
    check(prim_valid == (m_mode == 2), "R7 prim_valid", int'(prim_valid), int'(m_mode == 2));
    if (m_mode == 2 && prim_valid) begin
      check(int'(prim_time) == e_time, "R6 time", int'(prim_time), e_time);
      check(int'(prim_count) == e_cnt, "R5 count", int'(prim_count), e_cnt);
      check(int'(prim_sat) == e_sat, "R5 sat", int'(prim_sat), e_sat);
    end
    if (prim_valid) begin
      got_time.push_back(int'(prim_time));
      got_cnt.push_back(int'(prim_count));
      got_sat.push_back(int'(prim_sat));
    end
    if (m_mode == 2) begin m_mode = 0; m_cnt = 0; m_idle = 0; end
    else if (m_mode == 1) begin if (m_t == 0) m_mode = 2; else m_t--; end
    else if (do_close) begin
      m_mode = 1; m_t = SW;
      e_time = m_sum / m_acc; e_cnt = m_cnt; e_sat = (m_cnt > MAXH);
    end
    @(posedge clk); #1;
    if (pop_idx >= 0) void'(q[pop_idx].pop_front());
    drive_inputs();
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic drain();
    for (int k = 0; k < 2000; k++) begin
      bit busy = (m_mode != 0) || (m_cnt != 0);
      for (int i = 0; i < NSRC; i++) if (q[i].size() > 0) busy = 1;
      if (!busy) break;
      step();
    end
  endtask

  task automatic expect_prim(input int idx, input int tm, input int cn, input int st, input string req);
    if (idx >= got_time.size()) begin
      check(0, {req, " missing primitive"}, got_time.size(), idx + 1);
    end else begin
      check(got_time[idx] == tm, {req, " time"}, got_time[idx], tm);
      check(got_cnt[idx] == cn, {req, " count"}, got_cnt[idx], cn);
      check(got_sat[idx] == st, {req, " sat"}, got_sat[idx], st);
    end
  endtask

  task automatic clear_got();
    got_time.delete(); got_cnt.delete(); got_sat.delete();
  endtask

  task automatic push(input int s, input int tm);
    q[s].push_back(tm);
    drive_inputs();
  endtask

  function automatic int rnd(input int m);
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]) % m;
  endfunction

  initial begin
    rst_n = 1'b0; cfg_window = '0; src_valid = '0; src_time = '0;
    m_mode = 0; m_cnt = 0; m_acc = 0; m_sum = 0; m_first = 0; m_idle = 0; m_t = 0;
    e_time = 0; e_cnt = 0; e_sat = 0;
    repeat (3) @(negedge clk);
    check(prim_valid == 1'b0, "R8 reset prim_valid", int'(prim_valid), 0);
    check(src_pop == '0, "R8 reset pop", int'(src_pop), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    run(2);

    // window close then timeout close
    cfg_window = 16'd10;
    push(0, 100); push(0, 103); push(1, 101); push(2, 150);
    drain();
    check(got_time.size() == 2, "R3 R4 event number", got_time.size(), 2);
    expect_prim(0, 101, 3, 0, "R6 R3 first event");
    expect_prim(1, 150, 1, 0, "R4 timeout event");
    clear_got();

    // equal times on all sources
    cfg_window = 16'd5;
    for (int i = 0; i < NSRC; i++) push(i, 300);
    push(3, 302); push(0, 304);
    drain();
    expect_prim(0, 301, 6, 0, "R1 tie event");
    clear_got();

    // window edge: equal joins, one more closes
    cfg_window = 16'd10;
    push(1, 700); push(2, 710); push(3, 711);
    drain();
    expect_prim(0, 705, 2, 0, "R2 edge join");
    expect_prim(1, 711, 1, 0, "R3 beyond edge");
    clear_got();

    // accumulator limit
    cfg_window = 16'd100;
    for (int k = 0; k < 20; k++) push(1, 200 + k);
    drain();
    expect_prim(0, 207, 20, 1, "R5 saturation");
    clear_got();

    // count saturation at 63
    cfg_window = 16'd1000;
    for (int k = 0; k < 70; k++) push(k % NSRC, 2000 + k);
    drain();
    expect_prim(0, 2007, CMAX, 1, "R5 count limit");
    clear_got();

    // idle gap shorter than the timeout keeps the event open
    cfg_window = 16'd1000;
    push(2, 500); run(TIMEOUT - 2); push(0, 505);
    drain();
    check(got_time.size() == 1, "R4 short gap", got_time.size(), 1);
    expect_prim(0, 502, 2, 0, "R4 short gap");
    clear_got();

    // gap reaching the timeout splits the hits
    push(3, 600); run(TIMEOUT + 4); push(3, 601);
    drain();
    check(got_time.size() == 2, "R4 long gap", got_time.size(), 2);
    expect_prim(0, 600, 1, 0, "R4 long gap first");
    expect_prim(1, 601, 1, 0, "R4 long gap second");
    clear_got();

    // random sorted streams, checked against the model every cycle
    for (int r = 0; r < 12; r++) begin
      cfg_window = TW'(1 + rnd(40));
      for (int i = 0; i < NSRC; i++) begin
        int tm = 5000 + r * 3000 + rnd(20);
        for (int k = 0; k < 5 + rnd(15); k++) begin
          push(i, tm);
          tm += rnd(30);
        end
      end
      drain();
      run(rnd(12));
    end
    check(got_time.size() > 12, "R7 random primitives seen", got_time.size(), 13);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule